// File: doc/BRIEF.md
# SATA Link Bring-Up Sequencer

This block is a hardware state machine that brings the serial link of one SATA port from reset to an established state. When a start request arrives, it asserts the port's link-reset control value for a fixed number of millisecond ticks. It then releases the reset and waits a further fixed interval. Next it emits a one-cycle hook strobe, so that optional PHY adjustment logic outside the block can run, and it waits for that logic to answer with a hook-done input.

Once the hook is done, the block samples the 4-bit device-detection status on each millisecond tick. A detection code of 3 means the link is up, and the block reports success. If the polling window runs out, the outcome depends on the last sample. A zero means no device is attached, and the block reports failure. A nonzero value that is not 3 means a device is present but the link is not ready, so the whole reset pulse is issued again and the window starts over.

Every outcome ends in a single-cycle done or fail pulse, after which the block is idle and accepts the next start request.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, ctrl_o equals the released control value 0x300, and done_o, fail_o and hook_o are low.
- R2: A start_i pulse seen in idle makes ctrl_o equal the reset-asserted value 0x301 one cycle later. ctrl_o holds that value until RESET_MS millisecond ticks have been counted, and it returns to 0x300 in the cycle after the last of those ticks.
- R3: After the release, once SETTLE_MS further ticks have been counted, hook_o is high for exactly the one cycle following the last of those ticks.
- R4: Between the hook strobe and hook_done_i, ticks and status values have no effect: done_o, fail_o and hook_o stay low and ctrl_o stays 0x300. A hook_done_i seen in the strobe cycle itself is accepted.
- R5: While polling, a tick with det_i equal to 3 makes done_o high for one cycle, in the cycle after that tick, and the block returns to idle.
- R6: While polling, det_i is sampled only in cycles with ms_tick_i high. A value of 3 with no tick ends nothing.
- R7: If the POLL_LIMIT-th polling tick samples det_i equal to 0, fail_o is high for one cycle, in the cycle after that tick, and the block returns to idle.
- R8: If the POLL_LIMIT-th polling tick samples a det_i that is neither 0 nor 3, ctrl_o becomes 0x301 in the next cycle and the complete sequence (reset, release, hook, polling) runs again without a new start request.
- R9: start_i has no effect while a sequence is in progress.
- R10: done_o, fail_o and hook_o are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a bring-up sequence |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| det_i | input | DET_W | Device-detection status field from the port |
| hook_done_i | input | 1 | Indicates the external PHY adjustment step is finished |
| ctrl_o | output | CTRL_W | Control value driven to the port's link control register |
| hook_o | output | 1 | One-cycle strobe requesting the PHY adjustment step |
| done_o | output | 1 | One-cycle pulse: link established |
| fail_o | output | 1 | One-cycle pulse: no device detected |

## Verification
The assertions assume that ms_tick_i is a pulse and that det_i is stable in any cycle where the tick is high. This lets them tie each done or fail pulse to the status value present at the previous tick edge. The stimulus drives ticks as isolated single-cycle pulses separated by random idle gaps. It changes det_i only in cycles without a tick, and it sets det_i to 3 during those gaps so that sampling off the tick would be exposed. Random detection sequences mix absent, present and linked codes, so some runs retry several times. Directed runs also fire start requests in the middle of a sequence and hold the hook answer back for several ticks.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RESET  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_HOOK   = 3'd3,
    ST_POLL   = 3'd4
  } lbs_state_e;

  typedef enum logic [1:0] {
    DET_ABSENT  = 2'd0,
    DET_PRESENT = 2'd1,
    DET_LINKED  = 2'd2
  } lbs_det_e;

endpackage

// File: rtl/lbs_ms_timer.sv
module lbs_ms_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == limit_i - 1'b1);
  assign expire_o = tick_i && at_last;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lbs_det_eval.sv
module lbs_det_eval #(
  parameter int          DET_W  = 4,
  parameter logic [DET_W-1:0] DET_UP = 4'h3
) (
  input  logic [DET_W-1:0] det_i,
  output lbs_pkg::lbs_det_e class_o
);

  import lbs_pkg::*;

  always_comb begin
    if (det_i == DET_UP) begin
      class_o = DET_LINKED;
    end else if (det_i == '0) begin
      class_o = DET_ABSENT;
    end else begin
      class_o = DET_PRESENT;
    end
  end

endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm #(
  parameter int                CTRL_W     = 12,
  parameter logic [CTRL_W-1:0] CTRL_RESET = 12'h301,
  parameter logic [CTRL_W-1:0] CTRL_IDLE  = 12'h300,
  parameter int                CNT_W      = 3,
  parameter int                RESET_MS   = 1,
  parameter int                SETTLE_MS  = 1,
  parameter int                POLL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              expire_i,
  input  lbs_pkg::lbs_det_e det_class_i,
  input  logic              hook_done_i,
  output logic              timer_clr_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              hook_o,
  output logic              done_o,
  output logic              fail_o
);

  import lbs_pkg::*;

  localparam logic [CNT_W-1:0] LIM_RESET  = CNT_W'(RESET_MS);
  localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_MS);
  localparam logic [CNT_W-1:0] LIM_POLL   = CNT_W'(POLL_LIMIT);

  lbs_state_e        st_q, st_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              hook_q, hook_n;
  logic              done_q, done_n;
  logic              fail_q, fail_n;

  always_comb begin
    st_n   = st_q;
    ctrl_n = ctrl_q;
    hook_n = 1'b0;
    done_n = 1'b0;
    fail_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n   = ST_RESET;
          ctrl_n = CTRL_RESET;
        end
      end
      ST_RESET: begin
        if (expire_i) begin
          st_n   = ST_SETTLE;
          ctrl_n = CTRL_IDLE;
        end
      end
      ST_SETTLE: begin
        if (expire_i) begin
          st_n   = ST_HOOK;
          hook_n = 1'b1;
        end
      end
      ST_HOOK: begin
        if (hook_done_i) begin
          st_n = ST_POLL;
        end
      end
      ST_POLL: begin
        if (tick_i) begin
          if (det_class_i == DET_LINKED) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else if (expire_i) begin
            if (det_class_i == DET_ABSENT) begin
              st_n   = ST_IDLE;
              fail_n = 1'b1;
            end else begin
              st_n   = ST_RESET;
              ctrl_n = CTRL_RESET;
            end
          end
        end
      end
      default: begin
        st_n   = ST_IDLE;
        ctrl_n = CTRL_IDLE;
      end
    endcase
  end

  always_comb begin
    case (st_q)
      ST_RESET:  limit_o = LIM_RESET;
      ST_SETTLE: limit_o = LIM_SETTLE;
      default:   limit_o = LIM_POLL;
    endcase
  end

  assign timer_clr_o = (st_n != st_q) || (st_q == ST_IDLE) || (st_q == ST_HOOK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ctrl_q <= CTRL_IDLE;
      hook_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ctrl_q <= ctrl_n;
      hook_q <= hook_n;
      done_q <= done_n;
      fail_q <= fail_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign hook_o = hook_q;
  assign done_o = done_q;
  assign fail_o = fail_q;

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int                CTRL_W     = 12,
  parameter logic [CTRL_W-1:0] CTRL_RESET = 12'h301,
  parameter logic [CTRL_W-1:0] CTRL_IDLE  = 12'h300,
  parameter int                DET_W      = 4,
  parameter logic [DET_W-1:0]  DET_UP     = 4'h3,
  parameter int                RESET_MS   = 1,
  parameter int                SETTLE_MS  = 1,
  parameter int                POLL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ms_tick_i,
  input  logic [DET_W-1:0]  det_i,
  input  logic              hook_done_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              hook_o,
  output logic              done_o,
  output logic              fail_o
);

  localparam int MAX_A   = (RESET_MS > SETTLE_MS) ? RESET_MS : SETTLE_MS;
  localparam int MAX_LIM = (MAX_A > POLL_LIMIT) ? MAX_A : POLL_LIMIT;
  localparam int CNT_W   = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM + 1);

  logic              timer_clr;
  logic              expire;
  logic [CNT_W-1:0]  limit;
  lbs_pkg::lbs_det_e det_class;

  lbs_ms_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (timer_clr),
    .tick_i   (ms_tick_i),
    .limit_i  (limit),
    .expire_o (expire)
  );

  lbs_det_eval #(
    .DET_W  (DET_W),
    .DET_UP (DET_UP)
  ) u_det (
    .det_i   (det_i),
    .class_o (det_class)
  );

  lbs_fsm #(
    .CTRL_W     (CTRL_W),
    .CTRL_RESET (CTRL_RESET),
    .CTRL_IDLE  (CTRL_IDLE),
    .CNT_W      (CNT_W),
    .RESET_MS   (RESET_MS),
    .SETTLE_MS  (SETTLE_MS),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .tick_i      (ms_tick_i),
    .expire_i    (expire),
    .det_class_i (det_class),
    .hook_done_i (hook_done_i),
    .timer_clr_o (timer_clr),
    .limit_o     (limit),
    .ctrl_o      (ctrl_o),
    .hook_o      (hook_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
  );

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int                CTRL_W     = 12,
  parameter logic [CTRL_W-1:0] CTRL_RESET = 12'h301,
  parameter logic [CTRL_W-1:0] CTRL_IDLE  = 12'h300,
  parameter int                DET_W      = 4,
  parameter logic [DET_W-1:0]  DET_UP     = 4'h3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              ms_tick_i,
  input logic [DET_W-1:0]  det_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              hook_o,
  input logic              done_o,
  input logic              fail_o
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_o == CTRL_IDLE && !done_o && !fail_o && !hook_o));

  assert_ctrl_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o == CTRL_IDLE) || (ctrl_o == CTRL_RESET));

  assert_reset_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o == CTRL_RESET && $past(ctrl_o) == CTRL_IDLE) |-> ($past(start_i) || $past(ms_tick_i)));

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o == CTRL_IDLE && $past(ctrl_o) == CTRL_RESET) |-> $past(ms_tick_i));

  assert_hook_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
    hook_o |-> ($past(ms_tick_i) && $past(ctrl_o) == CTRL_IDLE));

  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(ms_tick_i) && $past(det_i) == DET_UP));

  assert_fail_cause_R7: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> ($past(ms_tick_i) && $past(det_i) == '0));

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, fail_o, hook_o}));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_fail_single_R10: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o);

  assert_hook_single_R10: assert property (@(posedge clk) disable iff (rst)
    hook_o |=> !hook_o);

endmodule

bind link_bringup_seq lbs_checker #(
  .CTRL_W     (CTRL_W),
  .CTRL_RESET (CTRL_RESET),
  .CTRL_IDLE  (CTRL_IDLE),
  .DET_W      (DET_W),
  .DET_UP     (DET_UP)
) u_lbs_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .ms_tick_i (ms_tick_i),
  .det_i     (det_i),
  .ctrl_o    (ctrl_o),
  .hook_o    (hook_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RESET_MS   = 2;
  localparam int SETTLE_MS  = 2;
  localparam int POLL_LIMIT = 4;
  localparam int PAT_MAX    = 32;
  localparam logic [11:0] V_RST = 12'h301;
  localparam logic [11:0] V_REL = 12'h300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        ms_tick_i = 1'b0;
  logic [3:0]  det_i = 4'h0;
  logic        hook_done_i = 1'b0;
  logic [11:0] ctrl_o;
  logic        hook_o, done_o, fail_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [3:0] pat [PAT_MAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(
    .RESET_MS   (RESET_MS),
    .SETTLE_MS  (SETTLE_MS),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_link_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ms_tick_i(ms_tick_i),
    .det_i(det_i), .hook_done_i(hook_done_i), .ctrl_o(ctrl_o),
    .hook_o(hook_o), .done_o(done_o), .fail_o(fail_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d expected=%0d cycles", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick_once();
    ms_tick_i = 1'b1;
    cyc();
    ms_tick_i = 1'b0;
  endtask

  task automatic gap(input int n, input bit poke_start);
    for (int i = 0; i < n; i++) begin
      start_i = poke_start;
      cyc();
      start_i = 1'b0;
      chk(!done_o && !fail_o, "R9 no outcome during gap", {done_o, fail_o}, 0);
    end
  endtask

  // 0 = done, 1 = fail, computed from the requirements
  function automatic int predict(input int n);
    for (int i = 0; i < n; i++) begin
      if (pat[i] == 4'h3) return 0;
      if ((i % POLL_LIMIT) == POLL_LIMIT - 1 && pat[i] == 4'h0) return 1;
    end
    return 1;
  endfunction

  task automatic run_seq(input int n, input int hook_lag, input bit poke);
    int idx = 0;
    int outcome = -1;
    int want = predict(n);
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    chk(ctrl_o == V_RST, "R2 reset value after start", ctrl_o, V_RST);
    while (outcome < 0) begin
      for (int i = 0; i < RESET_MS; i++) begin
        gap($urandom % 3, poke);
        chk(ctrl_o == V_RST, "R9 reset held despite start", ctrl_o, V_RST);
        tick_once();
        if (i < RESET_MS - 1)
          chk(ctrl_o == V_RST, "R2 reset held", ctrl_o, V_RST);
        else
          chk(ctrl_o == V_REL, "R2 release after ticks", ctrl_o, V_REL);
      end
      for (int i = 0; i < SETTLE_MS; i++) begin
        gap($urandom % 3, poke);
        tick_once();
        chk(hook_o == (i == SETTLE_MS - 1), "R3 hook strobe", hook_o, i == SETTLE_MS - 1);
      end
      for (int j = 0; j < hook_lag; j++) begin
        det_i = 4'h3;
        tick_once();
        chk(!hook_o && !done_o && !fail_o && ctrl_o == V_REL, "R4 ignored before hook done",
            {hook_o, done_o, fail_o}, 0);
      end
      hook_done_i = 1'b1;
      cyc();
      hook_done_i = 1'b0;
      chk(!hook_o, "R10 hook one cycle", hook_o, 0);
      for (int k = 0; k < POLL_LIMIT && outcome < 0; k++) begin
        det_i = 4'h3;
        gap($urandom % 3, 1'b0);
        chk(!done_o, "R6 no sample without tick", done_o, 0);
        det_i = pat[idx];
        tick_once();
        if (pat[idx] == 4'h3) begin
          chk(done_o && !fail_o, "R5 done on linked sample", done_o, 1);
          outcome = 0;
        end else if (k == POLL_LIMIT - 1 && pat[idx] == 4'h0) begin
          chk(fail_o && !done_o, "R7 fail on empty last sample", fail_o, 1);
          outcome = 1;
        end else if (k == POLL_LIMIT - 1) begin
          chk(ctrl_o == V_RST && !fail_o, "R8 retry reissues reset", ctrl_o, V_RST);
        end else begin
          chk(!done_o && !fail_o, "R5 no outcome mid window", {done_o, fail_o}, 0);
        end
        idx++;
      end
    end
    cyc();
    chk(!done_o && !fail_o && ctrl_o == V_REL, "R10 pulse ends, idle",
        {done_o, fail_o}, 0);
    chk(outcome == want, "R8 outcome matches prediction", outcome, want);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) cyc();
    chk(ctrl_o == V_REL && !done_o && !fail_o && !hook_o, "R1 state in reset", ctrl_o, V_REL);
    rst = 1'b0;
    cyc();
    chk(ctrl_o == V_REL && !done_o && !fail_o && !hook_o, "R1 state after reset", ctrl_o, V_REL);

    // directed: immediate link
    pat[0] = 4'h3;
    run_seq(1, 0, 1'b0);
    // directed: nothing attached
    for (int i = 0; i < POLL_LIMIT; i++) pat[i] = 4'h0;
    run_seq(POLL_LIMIT, 1, 1'b1);
    // directed: present but not ready, one retry, then linked
    for (int i = 0; i < POLL_LIMIT; i++) pat[i] = 4'h1;
    pat[POLL_LIMIT] = 4'h0;
    pat[POLL_LIMIT + 1] = 4'h3;
    run_seq(POLL_LIMIT + 2, 3, 1'b1);
    // directed: linked on last sample of window
    pat[0] = 4'h0; pat[1] = 4'h4; pat[2] = 4'h1; pat[3] = 4'h3;
    run_seq(4, 2, 1'b0);

    // random mix
    for (int s = 0; s < 30; s++) begin
      for (int i = 0; i < PAT_MAX; i++) begin
        int r = $urandom % 10;
        pat[i] = (r < 2) ? 4'h0 : (r < 4) ? 4'h3 : 4'(1 + ($urandom % 15));
        if (pat[i] == 4'h3 && r >= 4) pat[i] = 4'h1;
      end
      pat[PAT_MAX - 1] = 4'h0;
      run_seq(PAT_MAX, $urandom % 4, s[0]);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule